// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast system clock into the quantum clock and bit-time segmentation used by a CAN bit engine. A programmable divider, with an optional halving stage ahead of it, produces a one-clock time-quantum tick. A segment sequencer counts quanta through a one-quantum synchronisation slot, a first phase segment and a second phase segment. It tells the bit engine when to sample the receive line and when to launch the next transmit bit.

The sequencer follows falling (recessive-to-dominant) edges on the receive line. While the bus is idle, an edge restarts the bit at once. During a frame, an edge stretches the first phase segment or trims the second, by at most the programmed jump width. The sampled bit comes either from a single sample or from a majority of three samples taken one quantum apart.

Configuration is written through a small byte-wide port. The writes take effect only while the controller holds the block in configuration mode. Holding the block also stops the divider and the sequencer.

Top module: `cbt_bit_timer`

## Requirements
- R1: While `rst_n` is low or `cfg_hold` is high, `tq_tick`, `sample_pt` and `tx_pt` are low and `rx_bit` reads 1. Releasing `cfg_hold` restarts the divider and starts a new bit at the synchronisation quantum.
- R2: A write to address 0 stores the divider field F in bits [5:0] and the jump-width field J in bits [7:6]. Without halving, `tq_tick` pulses for one clock every 2*(F+1) clocks.
- R3: A write to address 2 stores the halving enable in bit 0. When it is set, the tick period becomes 4*(F+1) clocks, so F=32 gives 132 clocks.
- R4: Writes take effect only when `cfg_we` is high while `cfg_hold` is high. A write while running changes neither the tick period nor the bit timing.
- R5: A write to address 1 stores the phase-1 field P1 in bits [3:0], the phase-2 field P2 in bits [6:4] and the triple-sample enable in bit 7. With no edges, a bit lasts 1+(P1+1)+(P2+1) quanta. `sample_pt` pulses the clock after the tick that ends phase 1. `tx_pt` pulses the clock after the tick that ends phase 2.
- R6: An edge is a tick at which `rx_in` is 0 and the value captured at the previous tick was 1. An edge with `bus_idle` high is a hard synchronisation: the quantum just ended counts as the synchronisation quantum, phase 1 starts fresh, and `tx_pt` pulses.
- R7: An edge during phase 1 with `bus_idle` low, in quantum index q (from 0), lengthens phase 1 by min(q+1, J+1) quanta.
- R8: An edge during phase 2 with `bus_idle` low, in quantum index q, shortens phase 2 by min(P2-q, J+1) quanta. An edge in the synchronisation quantum causes no adjustment.
- R9: At most one adjustment (R6 to R8) is made between two sample points. A hard synchronisation also counts as that one.
- R10: With triple sampling off, `rx_bit` takes `rx_in` at the tick that ends phase 1. With it on, `rx_bit` takes the majority of `rx_in` at that tick and at the two preceding ticks. `rx_bit` updates together with `sample_pt`.
- R11: `sample_pt` and `tx_pt` are never high in the same clock, and `tq_tick` is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Controller in configuration mode; stops timing, opens writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0, 1, 2) |
| cfg_wdata | input | 8 | Configuration write data |
| bus_idle | input | 1 | High while the bit engine sees no frame; selects hard synchronisation |
| rx_in | input | 1 | Receive line, already synchronised to clk (0 = dominant) |
| tq_tick | output | 1 | One-clock pulse at the end of each time quantum |
| sample_pt | output | 1 | One-clock pulse at the sample point |
| tx_pt | output | 1 | One-clock pulse at the start of a bit |
| rx_bit | output | 1 | Sampled receive bit |

## Verification
On every cycle, the assertions bound the quantum counters against the programmed segment lengths plus any stretch or trim. They also check that a stretch never exceeds the jump width, that the configuration stays frozen while running, and that the pulses keep their spacing and stay exclusive. Whether a particular edge lengthened or shortened the right segment by the right amount, whether a glitch was voted out, and the exact clock of each pulse can only be shown by the bench. The bench drives idle edges, in-frame edges at drifting phases and short glitches, and compares every output on every clock against its own model.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
  parameter int BRP_W  = 6,
  parameter int SJW_W  = 2,
  parameter int TS1_W  = 4,
  parameter int TS2_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [BRP_W-1:0]  brp,
  output logic [SJW_W-1:0]  sjw,
  output logic [TS1_W-1:0]  ts1,
  output logic [TS2_W-1:0]  ts2,
  output logic              triple,
  output logic              prediv
);
  localparam int W0 = BRP_W + SJW_W;
  localparam int W1 = TS1_W + TS2_W + 1;

  logic [W0-1:0] r0;
  logic [W1-1:0] r1;
  logic          r2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0 <= '0;
      r1 <= '0;
      r2 <= 1'b0;
    end else if (we && hold) begin
      case (addr)
        2'd0:    r0 <= wdata[W0-1:0];
        2'd1:    r1 <= wdata[W1-1:0];
        2'd2:    r2 <= wdata[0];
        default: ;
      endcase
    end
  end

  assign brp    = r0[BRP_W-1:0];
  assign sjw    = r0[W0-1:BRP_W];
  assign ts1    = r1[TS1_W-1:0];
  assign ts2    = r1[TS1_W+TS2_W-1:TS1_W];
  assign triple = r1[W1-1];
  assign prediv = r2;

  // R4: configuration frozen while the block is running
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> ($stable(r0) && $stable(r1) && $stable(r2)));
endmodule

// File: rtl/cbt_tq_gen.sv
module cbt_tq_gen #(
  parameter int BRP_W     = 6,
  parameter bit PREDIV_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp,
  input  logic             prediv,
  output logic             tick
);
  localparam int CW = BRP_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          en;

  assign lim = {brp, 1'b1};

  generate
    if (PREDIV_EN) begin : g_half
      logic half;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    half <= 1'b0;
        else if (hold) half <= 1'b0;
        else if (prediv) half <= ~half;
        else           half <= 1'b0;
      end
      assign en = !prediv || half;
    end else begin : g_nohalf
      logic unused_prediv;
      assign unused_prediv = prediv;
      assign en = 1'b1;
    end
  endgenerate

  assign tick = !hold && en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (en)     cnt <= cnt + CW'(1);
  end

  // R11: a quantum is at least two clocks long
  a_r11_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             bus_idle,
  input  logic             rx_in,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  input  logic             triple,
  output logic             sample_pt,
  output logic             tx_pt,
  output logic             rx_bit
);
  localparam int MW = (TS1_W > SJW_W) ? TS1_W : SJW_W;
  localparam int QW = MW + 2;

  seg_e          seg;
  logic [QW-1:0] qcnt, ext, shr;
  logic          synced;
  logic [1:0]    hist;

  logic [QW-1:0] len1, len2, sjq, qp1, rem2, ext_lim, shr_lim, ext_eff, shr_eff;
  logic          edge_hit, do_hard, do_rs, end1, end2;

  always_comb begin
    len1     = QW'(ts1) + QW'(1);
    len2     = QW'(ts2) + QW'(1);
    sjq      = QW'(sjw) + QW'(1);
    qp1      = qcnt + QW'(1);
    rem2     = len2 - qp1;
    ext_lim  = (qp1 < sjq) ? qp1 : sjq;
    shr_lim  = (rem2 < sjq) ? rem2 : sjq;
    edge_hit = tick && hist[0] && !rx_in;
    do_hard  = edge_hit && bus_idle;
    do_rs    = edge_hit && !bus_idle && !synced;
    ext_eff  = (seg == SEG_PH1 && do_rs) ? ext_lim : ext;
    shr_eff  = (seg == SEG_PH2 && do_rs) ? shr_lim : shr;
    end1     = (qcnt == len1 + ext_eff - QW'(1));
    end2     = (qcnt == len2 - shr_eff - QW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_SYNC; qcnt <= '0; ext <= '0; shr <= '0; synced <= 1'b0;
      hist <= 2'b11; sample_pt <= 1'b0; tx_pt <= 1'b0; rx_bit <= 1'b1;
    end else if (hold) begin
      seg <= SEG_SYNC; qcnt <= '0; ext <= '0; shr <= '0; synced <= 1'b0;
      hist <= 2'b11; sample_pt <= 1'b0; tx_pt <= 1'b0; rx_bit <= 1'b1;
    end else begin
      sample_pt <= 1'b0;
      tx_pt     <= 1'b0;
      if (tick) begin
        hist <= {hist[0], rx_in};
        if (do_hard) begin
          seg <= SEG_PH1; qcnt <= '0; ext <= '0; shr <= '0;
          synced <= 1'b1; tx_pt <= 1'b1;
        end else begin
          case (seg)
            SEG_SYNC: begin
              seg <= SEG_PH1; qcnt <= '0;
            end
            SEG_PH1: begin
              if (end1) begin
                seg <= SEG_PH2; qcnt <= '0; ext <= '0;
                sample_pt <= 1'b1; synced <= 1'b0;
                rx_bit <= triple ? vote3(hist[1], hist[0], rx_in) : rx_in;
              end else begin
                qcnt <= qp1; ext <= ext_eff; synced <= synced | do_rs;
              end
            end
            SEG_PH2: begin
              synced <= synced | do_rs;
              if (end2) begin
                seg <= SEG_SYNC; qcnt <= '0; shr <= '0; tx_pt <= 1'b1;
              end else begin
                qcnt <= qp1; shr <= shr_eff;
              end
            end
            default: begin
              seg <= SEG_SYNC; qcnt <= '0;
            end
          endcase
        end
      end
    end
  end

  a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sample_pt && !tx_pt && rx_bit));
  a_r5_ph1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_PH1) |-> (qcnt < len1 + ext));
  a_r8_ph2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_PH2) |-> (qcnt + shr < len2));
  a_r7_ext_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ext <= sjq);
  a_r5_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> $past(tick));
  a_r11_pts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && tx_pt));
endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer #(
  parameter int BRP_W     = 6,
  parameter int SJW_W     = 2,
  parameter int TS1_W     = 4,
  parameter int TS2_W     = 3,
  parameter bit PREDIV_EN = 1'b1,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hold,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_idle,
  input  logic              rx_in,
  output logic              tq_tick,
  output logic              sample_pt,
  output logic              tx_pt,
  output logic              rx_bit
);
  logic [BRP_W-1:0] brp;
  logic [SJW_W-1:0] sjw;
  logic [TS1_W-1:0] ts1;
  logic [TS2_W-1:0] ts2;
  logic             triple, prediv;

  cbt_cfg_regs #(.BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
                 .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .brp(brp), .sjw(sjw), .ts1(ts1), .ts2(ts2),
    .triple(triple), .prediv(prediv));

  cbt_tq_gen #(.BRP_W(BRP_W), .PREDIV_EN(PREDIV_EN)) u_tq (
    .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .brp(brp), .prediv(prediv),
    .tick(tq_tick));

  cbt_bit_fsm #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .tick(tq_tick),
    .bus_idle(bus_idle), .rx_in(rx_in), .sjw(sjw), .ts1(ts1), .ts2(ts2),
    .triple(triple), .sample_pt(sample_pt), .tx_pt(tx_pt), .rx_bit(rx_bit));
endmodule

// File: tb/cbt_bit_timer_test.sv
module cbt_bit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_hold = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       bus_idle = 1'b0;
  logic       rx_in = 1'b1;
  logic       tq_tick, sample_pt, tx_pt, rx_bit;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  cbt_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .bus_idle(bus_idle),
    .rx_in(rx_in), .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt),
    .rx_bit(rx_bit));

  // behavioural reference model
  int m_brp = 0, m_sjw = 0, m_ts1 = 0, m_ts2 = 0;
  bit m_tri = 0, m_pd = 0;
  int m_k = 0, m_seg = 0, m_q = 0, m_ext = 0, m_shr = 0;
  bit m_sync = 0, m_sp = 0, m_tp = 0, m_bit = 1, m_h0 = 1, m_h1 = 1;

  function automatic int period();
    return 2 * (m_brp + 1) * (m_pd ? 2 : 1);
  endfunction
  function automatic bit m_tick();
    return rst_n && !cfg_hold && (m_k == period() - 1);
  endfunction
  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_brp = 0; m_sjw = 0; m_ts1 = 0; m_ts2 = 0; m_tri = 0; m_pd = 0;
      m_k = 0; m_seg = 0; m_q = 0; m_ext = 0; m_shr = 0; m_sync = 0;
      m_sp = 0; m_tp = 0; m_bit = 1; m_h0 = 1; m_h1 = 1;
    end else begin
      bit t;
      t = m_tick();
      if (cfg_hold) begin
        m_seg = 0; m_q = 0; m_ext = 0; m_shr = 0; m_sync = 0;
        m_sp = 0; m_tp = 0; m_bit = 1; m_h0 = 1; m_h1 = 1;
      end else begin
        m_sp = 0; m_tp = 0;
        if (t) begin
          bit edg, rs;
          int l1, l2, sj, e, s;
          edg = m_h0 && !rx_in;
          rs = edg && !bus_idle && !m_sync;
          l1 = m_ts1 + 1; l2 = m_ts2 + 1; sj = m_sjw + 1;
          if (edg && bus_idle) begin
            m_seg = 1; m_q = 0; m_ext = 0; m_shr = 0; m_sync = 1; m_tp = 1;
          end else if (m_seg == 0) begin
            m_seg = 1; m_q = 0;
          end else if (m_seg == 1) begin
            e = rs ? imin(m_q + 1, sj) : m_ext;
            if (m_q == l1 + e - 1) begin
              m_seg = 2; m_q = 0; m_ext = 0; m_sp = 1; m_sync = 0;
              m_bit = m_tri ? ((m_h1 + m_h0 + rx_in) >= 2) : rx_in;
            end else begin
              m_q++; m_ext = e; if (rs) m_sync = 1;
            end
          end else begin
            s = rs ? imin(l2 - 1 - m_q, sj) : m_shr;
            if (rs) m_sync = 1;
            if (m_q == l2 - s - 1) begin
              m_seg = 0; m_q = 0; m_shr = 0; m_tp = 1;
            end else begin
              m_q++; m_shr = s;
            end
          end
          m_h1 = m_h0; m_h0 = rx_in;
        end
      end
      if (cfg_hold || t) m_k = 0; else m_k++;
      if (cfg_we && cfg_hold) begin
        case (cfg_addr)
          2'd0: begin m_brp = cfg_wdata[5:0]; m_sjw = cfg_wdata[7:6]; end
          2'd1: begin m_ts1 = cfg_wdata[3:0]; m_ts2 = cfg_wdata[6:4]; m_tri = cfg_wdata[7]; end
          2'd2: m_pd = cfg_wdata[0];
          default: ;
        endcase
      end
    end
    started = 1'b1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R2", "tq_tick", tq_tick, m_tick());
      chk("R5", "sample_pt", sample_pt, m_sp);
      chk("R6", "tx_pt", tx_pt, m_tp);
      chk("R10", "rx_bit", rx_bit, m_bit);
      chk("R11", "pulse overlap", sample_pt && tx_pt, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gap_tick(output int n);
    do @(negedge clk); while (!tq_tick);
    n = 0;
    do begin @(negedge clk); n++; end while (!tq_tick);
  endtask

  task automatic gap_tx(output int n);
    do @(negedge clk); while (!tx_pt);
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_pt);
  endtask

  initial begin
    int g;
    idle(3);
    // R1: reset state
    chk("R1", "reset tq_tick", tq_tick, 0);
    chk("R1", "reset sample_pt", sample_pt, 0);
    chk("R1", "reset rx_bit", rx_bit, 1);
    rst_n = 1'b1;
    idle(2);
    // R2/R5: F=1 (4 clocks/quantum), J=1, P1=3, P2=2 -> 8 quanta per bit
    wr(2'd0, 8'b01_000001);
    wr(2'd1, 8'b0_010_0011);
    cfg_hold = 1'b0;
    gap_tick(g); chk("R2", "quantum period", g, 4);
    gap_tx(g);   chk("R5", "bit period", g, 32);
    // R4: write while running is ignored
    wr(2'd0, 8'b00_000101);
    gap_tick(g); chk("R4", "period after ignored write", g, 4);
    gap_tx(g);   chk("R4", "bit after ignored write", g, 32);
    // R6: hard synchronisation while idle
    bus_idle = 1'b1;
    idle(13); rx_in = 1'b0; idle(50); rx_in = 1'b1; idle(27);
    rx_in = 1'b0; idle(9); rx_in = 1'b1; idle(40);
    // R7/R8/R9: in-frame edges at drifting phases
    bus_idle = 1'b0;
    for (int i = 0; i < 40; i++) begin
      rx_in = ~rx_in;
      idle(26 + (i * 7) % 13);
    end
    rx_in = 1'b1; idle(60);
    // R10: triple sampling with one-quantum glitches, wider jump width
    cfg_hold = 1'b1; idle(2);
    chk("R1", "hold sample_pt", sample_pt, 0);
    chk("R1", "hold tq_tick", tq_tick, 0);
    wr(2'd0, 8'b11_000001);
    wr(2'd1, 8'b1_100_0101);
    cfg_hold = 1'b0;
    for (int i = 0; i < 30; i++) begin
      idle(11 + (i * 5) % 17);
      rx_in = 1'b0; idle(4 + 4 * (i % 3)); rx_in = 1'b1;
    end
    idle(80);
    // R3: halving stage, F=32 -> 132 clocks per quantum
    cfg_hold = 1'b1;
    wr(2'd0, 8'b00_100000);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'b0_000_0000);
    cfg_hold = 1'b0;
    gap_tick(g); chk("R3", "halved quantum period", g, 132);
    gap_tx(g);   chk("R3", "halved bit period", g, 396);
    idle(20);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected<150000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule